// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is the pad-facing data register of a test access port. It wraps a row of bidirectional pad cells, plus any input-only and output-only pins, in one serial chain. Each bidirectional cell carries three stages: the pad value coming in, the value the core wants to drive out, and the core's drive enable. Two fixed bits for the test-data-out driver sit at the TDO end of the chain, and one update-control bit sits at the far end.

The block receives the test clock, the asynchronous test reset and the per-state strobes from an external TAP controller (capture, shift, update). It also takes two instruction decodes. The first says the chain is the selected data register. The second says that external test is active, so the parallel hold stage drives the pads in place of the core.

Capture and shift act on the rising test clock. Update acts on the falling test clock. The first bit presented at TDO is the driver-enable bit. The configuration-control pins (program, configuration clock and done) have no cells in this chain.

Top module: `bsr_top`

## Requirements
- R1: The chain is 3*NUM_BIDIR+NUM_IN+NUM_OUT+3 bits long, with the following positions:
  - bit 0 is the TDO driver enable and bit 1 is the TDO driver value;
  - bidirectional cell k holds pad input at bit 2+3k, output at 3+3k and enable at 4+3k;
  - input-only pin j is at 2+3*NUM_BIDIR+j, and output-only pin j follows the input-only pins;
  - the last bit is the update-control bit.
- R2: With the chain selected and the shift strobe high, each rising tck moves every bit one place toward bit 0 and loads tdi into the last bit. tdo always shows bit 0.
- R3: With the chain selected and the capture strobe high, a rising tck loads all cells at once:
  - each bidirectional cell takes padIn, coreOut and coreOe;
  - each input-only cell takes inOnlyPad, and each output-only cell takes outOnlyCore;
  - bit 0 takes 1, and bit 1 and the last bit take 0.
- R4: With the chain selected and the update strobe high, a falling tck copies the shift stage into the hold stage. The hold stage, and so every pad it drives, stays unchanged through shifting and capturing.
- R5: While extest is 1, padOut, padOe and outOnlyPad come from the hold stage's output, enable and output-only bits. While extest is 0, they equal coreOut, coreOe and outOnlyCore.
- R6: While selBsr is 0, the capture, shift and update strobes change neither the shift stage nor the hold stage.
- R7: A low trstN clears the shift and hold stages at once, so tdo is 0, and under extest every pad output and enable is 0.
- R8: tdoEnHold, tdoValHold and updCtl present hold-stage bits 0, 1 and the last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| selBsr | input | 1 | Instruction decode: this chain is the selected data register |
| extest | input | 1 | Instruction decode: hold stage drives the pads |
| captureDr | input | 1 | Capture-state strobe |
| shiftDr | input | 1 | Shift-state strobe |
| updateDr | input | 1 | Update-state strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 0) |
| padIn | input | NUM_BIDIR | Values seen at the bidirectional pads |
| coreOut | input | NUM_BIDIR | Core output values for the bidirectional pads |
| coreOe | input | NUM_BIDIR | Core output enables for the bidirectional pads |
| padOut | output | NUM_BIDIR | Output value sent to each bidirectional pad |
| padOe | output | NUM_BIDIR | Output enable sent to each bidirectional pad |
| inOnlyPad | input | NUM_IN | Values seen at the input-only pins |
| outOnlyCore | input | NUM_OUT | Core values for the output-only pins |
| outOnlyPad | output | NUM_OUT | Values sent to the output-only pins |
| tdoEnHold | output | 1 | Hold-stage TDO driver enable |
| tdoValHold | output | 1 | Hold-stage TDO driver value |
| updCtl | output | 1 | Hold-stage update-control bit |

## Verification
A cell misplaced in the chain, or a shift that skips or repeats a stage, shows up at tdo. It appears as an out-of-order bit within one full chain length of shifting after a capture of known pad values. A hold stage loaded on the wrong edge or strobe shows up at the pads. Under extest, the pads either change during shifting or fail to change at the falling edge that ends the update cycle, so the fault is visible within that single test-clock cycle. A broken selection gate shows up the same way: the pads move, or stale data is read out at tdo, on the first shift sequence after the ignored strobes.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  // Strobes sent from the control half to the datapath half.
  typedef struct packed {
    logic capEn;
    logic shEn;
    logic updEn;
    logic drivePads;
  } bsrStrobe_t;

  // Two TDO-driver bits, three per bidirectional cell, one per single-direction
  // pin, and the trailing update-control bit.
  function automatic int chainLen(input int nBidir, input int nIn, input int nOut);
    return 3 * nBidir + nIn + nOut + 3;
  endfunction

endpackage

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
  import bsr_pkg::*;
(
  input  logic       tck,
  input  logic       trstN,
  input  logic       selBsr,
  input  logic       extest,
  input  logic       captureDr,
  input  logic       shiftDr,
  input  logic       updateDr,
  output bsrStrobe_t strobe
);

  always_comb begin
    strobe.capEn     = captureDr & selBsr;
    strobe.shEn      = shiftDr & selBsr;
    strobe.updEn     = updateDr & selBsr;
    strobe.drivePads = extest;
  end

  // R2 R3 R4: the controller presents at most one state strobe at a time
  strobe_onehot_chk: assert property (@(posedge tck) disable iff (!trstN)
    $onehot0({captureDr, shiftDr, updateDr}));

endmodule

// File: rtl/bsr_shift.sv
module bsr_shift
  import bsr_pkg::*;
#(
  parameter int NUM_BIDIR = 4,
  parameter int NUM_IN    = 2,
  parameter int NUM_OUT   = 2,
  localparam int CHAIN_LEN = chainLen(NUM_BIDIR, NUM_IN, NUM_OUT)
) (
  input  logic                 tck,
  input  logic                 trstN,
  input  bsrStrobe_t           strobe,
  input  logic                 tdi,
  input  logic [NUM_BIDIR-1:0] padIn,
  input  logic [NUM_BIDIR-1:0] coreOut,
  input  logic [NUM_BIDIR-1:0] coreOe,
  input  logic [NUM_IN-1:0]    inOnlyPad,
  input  logic [NUM_OUT-1:0]   outOnlyCore,
  output logic [CHAIN_LEN-1:0] shiftQ
);

  localparam int CELL_BASE = 2;
  localparam int IN_BASE   = CELL_BASE + 3 * NUM_BIDIR;
  localparam int OUT_BASE  = IN_BASE + NUM_IN;
  localparam int UPD_POS   = CHAIN_LEN - 1;

  logic [CHAIN_LEN-1:0] capVec;
  logic                 unusedStrobeBits;

  assign unusedStrobeBits = strobe.updEn ^ strobe.drivePads;

  // Parallel capture value assembled from the pad and core sides.
  always_comb begin
    capVec          = '0;
    capVec[0]       = 1'b1;
    capVec[1]       = 1'b0;
    capVec[UPD_POS] = 1'b0;
    for (int k = 0; k < NUM_BIDIR; k++) begin
      capVec[CELL_BASE + 3 * k]     = padIn[k];
      capVec[CELL_BASE + 3 * k + 1] = coreOut[k];
      capVec[CELL_BASE + 3 * k + 2] = coreOe[k];
    end
    for (int j = 0; j < NUM_IN; j++) capVec[IN_BASE + j] = inOnlyPad[j];
    for (int j = 0; j < NUM_OUT; j++) capVec[OUT_BASE + j] = outOnlyCore[j];
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)            shiftQ <= '0;
    else if (strobe.capEn) shiftQ <= capVec;
    else if (strobe.shEn)  shiftQ <= {tdi, shiftQ[CHAIN_LEN-1:1]};
  end

  // R2
  shift_entry_chk: assert property (@(posedge tck) disable iff (!trstN)
    strobe.shEn |=> (shiftQ[UPD_POS] == $past(tdi)) && (shiftQ[0] == $past(shiftQ[1])));

  // R3
  capture_load_chk: assert property (@(posedge tck) disable iff (!trstN)
    strobe.capEn |=> shiftQ[CELL_BASE] == $past(padIn[0]) && shiftQ[0]);

  // R6
  idle_hold_chk: assert property (@(posedge tck) disable iff (!trstN)
    (!strobe.capEn && !strobe.shEn) |=> $stable(shiftQ));

endmodule

// File: rtl/bsr_hold.sv
module bsr_hold
  import bsr_pkg::*;
#(
  parameter int NUM_BIDIR = 4,
  parameter int NUM_IN    = 2,
  parameter int NUM_OUT   = 2,
  localparam int CHAIN_LEN = chainLen(NUM_BIDIR, NUM_IN, NUM_OUT)
) (
  input  logic                 tck,
  input  logic                 trstN,
  input  bsrStrobe_t           strobe,
  input  logic [CHAIN_LEN-1:0] shiftQ,
  input  logic [NUM_BIDIR-1:0] coreOut,
  input  logic [NUM_BIDIR-1:0] coreOe,
  input  logic [NUM_OUT-1:0]   outOnlyCore,
  output logic [NUM_BIDIR-1:0] padOut,
  output logic [NUM_BIDIR-1:0] padOe,
  output logic [NUM_OUT-1:0]   outOnlyPad,
  output logic                 tdoEnHold,
  output logic                 tdoValHold,
  output logic                 updCtl
);

  localparam int CELL_BASE = 2;
  localparam int OUT_BASE  = CELL_BASE + 3 * NUM_BIDIR + NUM_IN;
  localparam int UPD_POS   = CHAIN_LEN - 1;

  logic [CHAIN_LEN-1:0] holdQ;
  logic                 unusedCap;

  assign unusedCap = strobe.capEn;

  // Parallel hold stage, loaded on the falling test clock.
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN)            holdQ <= '0;
    else if (strobe.updEn) holdQ <= shiftQ;
  end

  // Pad-side multiplexers, one per cell.
  for (genvar k = 0; k < NUM_BIDIR; k++) begin : gCell
    assign padOut[k] = strobe.drivePads ? holdQ[CELL_BASE + 3 * k + 1] : coreOut[k];
    assign padOe[k]  = strobe.drivePads ? holdQ[CELL_BASE + 3 * k + 2] : coreOe[k];
  end

  for (genvar j = 0; j < NUM_OUT; j++) begin : gOutOnly
    assign outOnlyPad[j] = strobe.drivePads ? holdQ[OUT_BASE + j] : outOnlyCore[j];
  end

  assign tdoEnHold  = holdQ[0];
  assign tdoValHold = holdQ[1];
  assign updCtl     = holdQ[UPD_POS];

  // R4
  hold_stable_chk: assert property (@(negedge tck) disable iff (!trstN)
    !strobe.updEn |=> $stable(holdQ));

  // R4
  shift_no_disturb_chk: assert property (@(posedge tck) disable iff (!trstN)
    strobe.shEn |=> $stable(holdQ));

  // R5
  pads_frozen_chk: assert property (@(negedge tck) disable iff (!trstN)
    (strobe.drivePads && $past(strobe.drivePads) && !$past(strobe.updEn))
      |-> ($stable(padOut) && $stable(padOe) && $stable(outOnlyPad)));

endmodule

// File: rtl/bsr_top.sv
module bsr_top
  import bsr_pkg::*;
#(
  parameter int NUM_BIDIR = 4,
  parameter int NUM_IN    = 2,
  parameter int NUM_OUT   = 2
) (
  input  logic                 tck,
  input  logic                 trstN,
  input  logic                 selBsr,
  input  logic                 extest,
  input  logic                 captureDr,
  input  logic                 shiftDr,
  input  logic                 updateDr,
  input  logic                 tdi,
  output logic                 tdo,
  input  logic [NUM_BIDIR-1:0] padIn,
  input  logic [NUM_BIDIR-1:0] coreOut,
  input  logic [NUM_BIDIR-1:0] coreOe,
  output logic [NUM_BIDIR-1:0] padOut,
  output logic [NUM_BIDIR-1:0] padOe,
  input  logic [NUM_IN-1:0]    inOnlyPad,
  input  logic [NUM_OUT-1:0]   outOnlyCore,
  output logic [NUM_OUT-1:0]   outOnlyPad,
  output logic                 tdoEnHold,
  output logic                 tdoValHold,
  output logic                 updCtl
);

  localparam int CHAIN_LEN = chainLen(NUM_BIDIR, NUM_IN, NUM_OUT);

  bsrStrobe_t           strobe;
  logic [CHAIN_LEN-1:0] shiftQ;

  bsr_ctrl uCtrl (
    .tck       (tck),
    .trstN     (trstN),
    .selBsr    (selBsr),
    .extest    (extest),
    .captureDr (captureDr),
    .shiftDr   (shiftDr),
    .updateDr  (updateDr),
    .strobe    (strobe)
  );

  bsr_shift #(.NUM_BIDIR(NUM_BIDIR), .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) uShift (
    .tck         (tck),
    .trstN       (trstN),
    .strobe      (strobe),
    .tdi         (tdi),
    .padIn       (padIn),
    .coreOut     (coreOut),
    .coreOe      (coreOe),
    .inOnlyPad   (inOnlyPad),
    .outOnlyCore (outOnlyCore),
    .shiftQ      (shiftQ)
  );

  bsr_hold #(.NUM_BIDIR(NUM_BIDIR), .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) uHold (
    .tck         (tck),
    .trstN       (trstN),
    .strobe      (strobe),
    .shiftQ      (shiftQ),
    .coreOut     (coreOut),
    .coreOe      (coreOe),
    .outOnlyCore (outOnlyCore),
    .padOut      (padOut),
    .padOe       (padOe),
    .outOnlyPad  (outOnlyPad),
    .tdoEnHold   (tdoEnHold),
    .tdoValHold  (tdoValHold),
    .updCtl      (updCtl)
  );

  assign tdo = shiftQ[0];

endmodule

// File: tb/tb_bsr_top.sv
module tb_bsr_top;

  localparam int PERIOD = 20;
  localparam int NB = 4;
  localparam int NI = 2;
  localparam int NO = 2;
  localparam int L  = 3 * NB + NI + NO + 3;
  localparam int IN_BASE  = 2 + 3 * NB;
  localparam int OUT_BASE = IN_BASE + NI;

  // Entry: [28:25] hold out, [24:21] hold oe, [20:19] hold out-only,
  // [18] tdo en, [17] tdo val, [16] update bit,
  // [15:12] padIn, [11:8] coreOut, [7:4] coreOe, [3:2] inOnlyPad, [1:0] outOnlyCore
  localparam logic [28:0] VEC [4] = '{
    29'b1010_0101_10_1_0_1_1100_0011_1001_01_10,
    29'b1111_1111_11_0_1_0_0001_1110_0110_10_01,
    29'b0000_1111_01_1_1_1_1111_0000_1111_11_00,
    29'b0110_1001_00_0_0_0_0000_1111_0000_00_11
  };

  logic tck = 1'b0;
  logic trstN, selBsr, extest, captureDr, shiftDr, updateDr, tdi;
  logic tdo;
  logic [NB-1:0] padIn, coreOut, coreOe, padOut, padOe;
  logic [NI-1:0] inOnlyPad;
  logic [NO-1:0] outOnlyCore, outOnlyPad;
  logic tdoEnHold, tdoValHold, updCtl;

  int nChecks = 0;
  int nFails  = 0;

  always #(PERIOD / 2) tck = ~tck;

  bsr_top #(.NUM_BIDIR(NB), .NUM_IN(NI), .NUM_OUT(NO)) dut (
    .tck(tck), .trstN(trstN), .selBsr(selBsr), .extest(extest),
    .captureDr(captureDr), .shiftDr(shiftDr), .updateDr(updateDr),
    .tdi(tdi), .tdo(tdo), .padIn(padIn), .coreOut(coreOut), .coreOe(coreOe),
    .padOut(padOut), .padOe(padOe), .inOnlyPad(inOnlyPad),
    .outOnlyCore(outOnlyCore), .outOnlyPad(outOnlyPad),
    .tdoEnHold(tdoEnHold), .tdoValHold(tdoValHold), .updCtl(updCtl)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One test-clock slot: rising edge in the middle, falling edge at the end.
  task automatic slot(input logic c, input logic s, input logic u, input logic d);
    captureDr = c; shiftDr = s; updateDr = u; tdi = d;
    @(negedge tck); #2;
    captureDr = 0; shiftDr = 0; updateDr = 0;
  endtask

  task automatic scan(input logic [L-1:0] inV, output logic [L-1:0] outV);
    for (int i = 0; i < L; i++) begin
      outV[i] = tdo;
      slot(1'b0, 1'b1, 1'b0, inV[i]);
    end
  endtask

  // Update pattern per the R1 layout.
  function automatic logic [L-1:0] packHold(input logic [28:0] e);
    logic [L-1:0] v = '0;
    v[0] = e[18];
    v[1] = e[17];
    for (int k = 0; k < NB; k++) begin
      v[3 + 3 * k] = e[25 + k];
      v[4 + 3 * k] = e[21 + k];
    end
    for (int j = 0; j < NO; j++) v[OUT_BASE + j] = e[19 + j];
    v[L-1] = e[16];
    return v;
  endfunction

  // Expected captured chain per R1 and R3.
  function automatic logic [L-1:0] capExp(input logic [28:0] e);
    logic [L-1:0] v = '0;
    v[0] = 1'b1;
    for (int k = 0; k < NB; k++) begin
      v[2 + 3 * k] = e[12 + k];
      v[3 + 3 * k] = e[8 + k];
      v[4 + 3 * k] = e[4 + k];
    end
    for (int j = 0; j < NI; j++) v[IN_BASE + j] = e[2 + j];
    for (int j = 0; j < NO; j++) v[OUT_BASE + j] = e[j];
    return v;
  endfunction

  initial begin
    #(PERIOD * 20000);
    nFails++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [L-1:0] got;
    logic [NB-1:0] prevOut, prevOe;
    logic [NO-1:0] prevOnly;
    trstN = 0; selBsr = 0; extest = 0; captureDr = 0; shiftDr = 0; updateDr = 0;
    tdi = 0; padIn = '0; coreOut = 4'b1100; coreOe = 4'b1010;
    inOnlyPad = '0; outOnlyCore = 2'b01;
    repeat (3) @(negedge tck);
    #2;
    // R7 reset state
    check("R7", "tdo after reset", tdo, 0);
    check("R8", "hold specials after reset", {tdoEnHold, tdoValHold, updCtl}, 0);
    // R5 core passthrough
    check("R5", "padOut from core", padOut, 4'b1100);
    check("R5", "padOe from core", padOe, 4'b1010);
    check("R5", "outOnlyPad from core", outOnlyPad, 2'b01);
    trstN = 1;
    extest = 1;
    #1;
    check("R7", "padOut under extest after reset", padOut, 0);
    check("R7", "padOe under extest after reset", padOe, 0);
    selBsr = 1;
    @(negedge tck); #2;

    prevOut = '0; prevOe = '0; prevOnly = '0;
    for (int n = 0; n < 4; n++) begin
      scan(packHold(VEC[n]), got);
      // R4: shifting leaves the driven pads alone
      check("R4", "padOut during shift", padOut, prevOut);
      check("R4", "padOe during shift", padOe, prevOe);
      slot(1'b0, 1'b0, 1'b1, 1'b0);
      check("R5", "padOut from hold", padOut, VEC[n][28:25]);
      check("R5", "padOe from hold", padOe, VEC[n][24:21]);
      check("R5", "outOnlyPad from hold", outOnlyPad, VEC[n][20:19]);
      check("R8", "hold specials", {tdoEnHold, tdoValHold, updCtl}, VEC[n][18:16]);
      prevOut = VEC[n][28:25]; prevOe = VEC[n][24:21]; prevOnly = VEC[n][20:19];
      padIn = VEC[n][15:12]; coreOut = VEC[n][11:8]; coreOe = VEC[n][7:4];
      inOnlyPad = VEC[n][3:2]; outOnlyCore = VEC[n][1:0];
      slot(1'b1, 1'b0, 1'b0, 1'b0);
      check("R2", "tdo after capture shows bit 0", tdo, 1);
      scan('0, got);
      check("R3", "captured chain order", got, capExp(VEC[n]));
      check("R4", "pads hold through capture", padOut, prevOut);
    end

    // R2: walking one appears at tdo after exactly L-1 further shifts
    slot(1'b0, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < L - 2; i++) slot(1'b0, 1'b1, 1'b0, 1'b0);
    check("R2", "walking one not yet out", tdo, 0);
    slot(1'b0, 1'b1, 1'b0, 1'b0);
    check("R2", "walking one at tdo", tdo, 1);
    slot(1'b0, 1'b1, 1'b0, 1'b0);
    check("R2", "walking one gone", tdo, 0);

    // R6: strobes ignored while deselected
    selBsr = 0;
    padIn = 4'b1111; coreOut = 4'b1111; coreOe = 4'b1111;
    slot(1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < L; i++) slot(1'b0, 1'b1, 1'b0, 1'b1);
    slot(1'b0, 1'b0, 1'b1, 1'b0);
    check("R6", "pads unchanged while deselected", padOut, prevOut);
    check("R6", "enables unchanged while deselected", padOe, prevOe);
    check("R6", "out-only unchanged while deselected", outOnlyPad, prevOnly);
    selBsr = 1;
    scan('0, got);
    check("R6", "shift stage unchanged while deselected", got, 0);

    // R5: leaving extest returns pads to the core
    extest = 0;
    #1;
    check("R5", "padOut back to core", padOut, 4'b1111);
    check("R5", "outOnlyPad back to core", outOnlyPad, outOnlyCore);

    // R7: mid-run reset clears both stages
    extest = 1;
    scan({L{1'b1}}, got);
    slot(1'b0, 1'b0, 1'b1, 1'b0);
    check("R5", "all-ones hold drives pads", padOe, 4'b1111);
    trstN = 0;
    #1;
    check("R7", "tdo cleared by reset", tdo, 0);
    check("R7", "pads cleared by reset", {padOut, padOe, outOnlyPad}, 0);
    check("R7", "specials cleared by reset", {tdoEnHold, tdoValHold, updCtl}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule